// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block is a small cache placed between a processor port and a main-memory port. Each line stores one data word, a tag and a valid flag. The line is selected by the low-order bits of the word address, and the remaining high-order bits form the tag. A read whose tag matches a valid line is answered in the cycle it is presented. A read that misses sends its address to memory. When the memory word returns, the block writes it into the line and passes it to the processor.

Writes use the write-through policy. Each accepted write replaces the line's tag and data and sets its valid flag, so a write miss needs no fetch. The same write also enters a four-entry posted write queue, which drains to memory oldest first. The processor waits on a write only while that queue is full.

A read miss does not go to memory until the queue is empty. As a result, a memory read always sees every write that was accepted before it. The memory port uses a request/grant handshake for both directions. Read data comes back on a separate valid strobe, at least one cycle after the grant, with a latency that can vary.

Top module: `wt_cache`

## Requirements
- R1: The line index is `cpu_addr[IDX_W-1:0]` and the tag is `cpu_addr[ADDR_W-1:IDX_W]`. A read hits only when the indexed line is valid and its stored tag equals the tag. Two addresses with the same index and different tags evict each other.
- R2: A read hit is acknowledged (`cpu_ack`=1) in the same cycle as the request. `cpu_rdata` then carries the stored word, and the hit causes no memory read.
- R3: A read miss with the write queue empty raises `mem_req` with `mem_we`=0 and `mem_addr` equal to the miss address from the next cycle onward. `cpu_ack` stays low until the fill.
- R4: In the cycle `mem_rvalid` is high for an outstanding read, `cpu_ack` is 1 and `cpu_rdata` equals `mem_rdata`. The word is written into the line, so a later read of that address hits.
- R5: A write is acknowledged in its request cycle when the queue holds fewer than four entries. The line takes the write's tag and data and becomes valid.
- R6: Every acknowledged write enters the queue. While the queue is not empty, the port shows the oldest entry with `mem_req`=1 and `mem_we`=1 and carries its address and data. Entries leave on `mem_gnt`, in first-in, first-out order.
- R7: While four writes are queued, a write request is not acknowledged until an entry has been granted.
- R8: A read miss that finds the queue non-empty issues no memory read until every queued write has been granted.
- R9: A synchronous active-low reset invalidates every line and empties the queue. During reset `cpu_ack` and `mem_req` are low, and the first read of any address after reset misses.
- R10: Read hits are served in their request cycle while the queue is draining.
- R11: Once `mem_req` is raised, it stays high with `mem_we`, `mem_addr` and `mem_wdata` unchanged until `mem_gnt` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req | input | 1 | Processor request, held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ack | output | 1 | Request completed this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ack` on a read |
| mem_req | output | 1 | Memory request, held until granted |
| mem_we | output | 1 | 1 = buffered write, 0 = line read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_gnt | input | 1 | Memory accepts the current request |
| mem_rvalid | input | 1 | Read data is valid |
| mem_rdata | input | DATA_W | Read data from memory |

## Verification
Corrupt line state, such as a stale valid flag, a wrong tag or a missed fill, shows up at the first access to the affected index. That access either acknowledges in the request cycle when it should stall, or stalls when it should not. Fault in the write queue, such as a lost entry, a reordering or a wrong count, shows on the memory port: a wrong address or data appears at the head when the next entry is granted. A count error also shows as a missing or extra stall once four writes are in flight. A read that overtakes pending writes raises a read request while writes are still outstanding. Later, once an aliasing write is evicted and the address is re-read, it also returns stale data. A cycle-accurate model compares the processor and memory ports on every clock, so each of these faults is reported in the cycle it first becomes visible.

// File: rtl/wtc_pkg.sv
// Shared types for the write-through cache.
// Assumes nothing beyond a two-bit state encoding.
package wtc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,  // accept hits and writes
        ST_DRAIN  = 2'd1,  // read miss waiting for queued writes to leave
        ST_RDREQ  = 2'd2,  // line read presented to memory
        ST_RDRESP = 2'd3   // line read granted, waiting for data
    } wtc_state_e;
endpackage

// File: rtl/wtc_store.sv
// Line storage: valid flag, tag and one data word per line.
// Lookup is combinational. A single write port updates one line per cycle.
// Assumes LINES is a power of two, so that any index value is in range.
module wtc_store #(
    parameter int LINES  = 16,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    logic              valid_q [LINES];
    logic [TAG_W-1:0]  tag_q   [LINES];
    logic [DATA_W-1:0] data_q  [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // Per-line register: reset clears valid, a write fills the line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                valid_q[g] <= 1'b1;
                tag_q[g]   <= wr_tag;
                data_q[g]  <= wr_data;
            end
        end
    end

    // Lookup: compare the stored tag of the indexed line.
    always_comb begin
        lk_hit  = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
        lk_data = data_q[lk_idx];
    end

    // R5 / R4: a line that was written holds that tag and word, and is valid, on the next cycle.
    p_written_line_hits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (valid_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)
                   && data_q[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/wtc_wbuf.sv
// Posted write queue: a first-in, first-out queue of address/data pairs.
// The head entry is always visible. Pushing while full or popping while empty is
// not allowed; the controller and the port logic guarantee this.
// Assumes DEPTH is a power of two, so the pointers wrap naturally.
module wtc_wbuf #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [ADDR_W-1:0] head_addr,
    output logic [DATA_W-1:0] head_data,
    output logic              empty,
    output logic              full
);
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0]  count_q;

    // Entry storage: write the tail on push.
    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[wr_ptr_q] <= push_addr;
            data_q[wr_ptr_q] <= push_data;
        end
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push) wr_ptr_q <= wr_ptr_q + PTR_W'(1);
            if (pop)  rd_ptr_q <= rd_ptr_q + PTR_W'(1);
            case ({push, pop})
                2'b10:   count_q <= count_q + CNT_W'(1);
                2'b01:   count_q <= count_q - CNT_W'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    // Head view and occupancy flags.
    always_comb begin
        head_addr = addr_q[rd_ptr_q];
        head_data = data_q[rd_ptr_q];
        empty     = (count_q == '0);
        full      = (count_q == CNT_W'(DEPTH));
    end

    // R7: the controller never pushes into a full queue.
    p_no_push_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R6: the port logic never pops an empty queue.
    p_no_pop_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    // R9: reset leaves the queue empty.
    p_reset_empty_r9: assert property (@(posedge clk)
        !rst_n |=> (count_q == '0));
endmodule

// File: rtl/wtc_ctrl.sv
// Sequencing for processor requests: hits and writes complete in the request
// cycle. A read miss waits for the write queue to empty, presents a line read,
// and completes when the memory data returns.
// Assumes the processor holds its request steady until it is acknowledged, and
// that read data arrives at least one cycle after the grant.
module wtc_ctrl
    import wtc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              lk_hit,
    input  logic              buf_empty,
    input  logic              buf_full,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    output logic              cpu_ack,
    output logic              push,
    output logic              fill,
    output logic              rd_req,
    output logic [ADDR_W-1:0] miss_addr
);
    wtc_state_e        state_q, state_d;
    logic [ADDR_W-1:0] miss_addr_q;
    logic              rd_miss;

    // Completion and strobe decode for this cycle.
    always_comb begin
        push    = (state_q == ST_IDLE) && cpu_req && cpu_we && !buf_full;
        rd_miss = (state_q == ST_IDLE) && cpu_req && !cpu_we && !lk_hit;
        fill    = (state_q == ST_RDRESP) && mem_rvalid;
        cpu_ack = push || fill || ((state_q == ST_IDLE) && cpu_req && !cpu_we && lk_hit);
        rd_req  = (state_q == ST_RDREQ);
    end

    // Next-state selection for the miss sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (rd_miss) state_d = buf_empty ? ST_RDREQ : ST_DRAIN;
            ST_DRAIN:  if (buf_empty) state_d = ST_RDREQ;
            ST_RDREQ:  if (mem_gnt) state_d = ST_RDRESP;
            ST_RDRESP: if (mem_rvalid) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and miss-address capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            miss_addr_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_miss) miss_addr_q <= cpu_addr;
        end
    end

    assign miss_addr = miss_addr_q;

    // R8: a line read is presented only when no buffered write remains.
    p_read_after_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> buf_empty);

    // R3: a read that misses leaves the idle state and so stalls the processor.
    p_miss_stalls_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && !lk_hit && state_q == ST_IDLE) |=> (state_q != ST_IDLE));
endmodule

// File: rtl/wt_cache.sv
// Top level of the direct-mapped write-through cache. It joins the line store,
// the posted write queue and the miss controller, and shares the single memory
// port: queued writes own it whenever any are present, and a line read uses it
// only once the queue is empty.
// Assumes LINES and WBUF_DEPTH are powers of two and that memory answers a read
// no earlier than the cycle after its grant.
module wt_cache #(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int LINES      = 16,
    parameter int WBUF_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ack,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic              lk_hit;
    logic [DATA_W-1:0] lk_data;
    logic              buf_empty, buf_full, push, pop, fill, rd_req;
    logic [ADDR_W-1:0] head_addr, miss_addr, line_addr;
    logic [DATA_W-1:0] head_data, line_data;

    wtc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .lk_hit(lk_hit), .buf_empty(buf_empty), .buf_full(buf_full),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .cpu_ack(cpu_ack), .push(push), .fill(fill),
        .rd_req(rd_req), .miss_addr(miss_addr)
    );

    // Line write source: the fill word at the miss address, otherwise the processor write.
    always_comb begin
        line_addr = fill ? miss_addr : cpu_addr;
        line_data = fill ? mem_rdata : cpu_wdata;
    end

    wtc_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(cpu_addr[IDX_W-1:0]), .lk_tag(cpu_addr[ADDR_W-1:IDX_W]),
        .lk_hit(lk_hit), .lk_data(lk_data),
        .wr_en(push || fill),
        .wr_idx(line_addr[IDX_W-1:0]), .wr_tag(line_addr[ADDR_W-1:IDX_W]),
        .wr_data(line_data)
    );

    wtc_wbuf #(.DEPTH(WBUF_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wbuf (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_addr(cpu_addr), .push_data(cpu_wdata),
        .pop(pop), .head_addr(head_addr), .head_data(head_data),
        .empty(buf_empty), .full(buf_full)
    );

    // Memory port sharing: queued writes first, then the pending line read.
    always_comb begin
        mem_req   = !buf_empty || rd_req;
        mem_we    = !buf_empty;
        mem_addr  = buf_empty ? miss_addr : head_addr;
        mem_wdata = head_data;
        pop       = !buf_empty && mem_gnt;
    end

    // Return data: the fill word during a fill, otherwise the stored word.
    assign cpu_rdata = fill ? mem_rdata : lk_data;

    // R11: an ungranted memory request keeps its fields unchanged.
    p_hold_until_gnt_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                   && (!mem_we || $stable(mem_wdata))));
endmodule

// File: tb/sim_wt_cache.sv
`timescale 1ns/1ps
module sim_wt_cache;
    localparam int AW = 12, DW = 32, LINES = 16, DEPTH = 4;
    localparam int IW = $clog2(LINES);
    localparam int NOPS = 420, RST_AT = 380;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic          rst_n = 1'b0, cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0, mem_rdata = '0;
    logic          mem_gnt = 1'b0, mem_rvalid = 1'b0;
    logic          cpu_ack, mem_req, mem_we;
    logic [DW-1:0] cpu_rdata, mem_wdata;
    logic [AW-1:0] mem_addr;

    wt_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(LINES), .WBUF_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack),
        .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    int errors = 0, checks = 0;

    // Reference model state
    typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; } ent_t;
    bit               mv [LINES];
    logic [AW-IW-1:0] mt [LINES];
    logic [DW-1:0]    md [LINES];
    logic [DW-1:0]    mem_m [int];
    ent_t             wq [$];
    int               mode = 0;          // 0 idle, 1 wait drain, 2 read request, 3 read response
    bit               rp = 0;            // responder holds a granted read
    int               rw = 0;
    logic [DW-1:0]    rd_d = '0;
    logic [15:0]      lfsr = 16'hACE1;
    int unsigned      cyc = 0;
    bit               prev_wait = 0;     // last cycle had an ungranted request
    bit               post_rst = 0;

    // Stimulus
    bit            op_we [NOPS];
    logic [AW-1:0] op_a  [NOPS];
    logic [DW-1:0] op_d  [NOPS];
    int            op_gm [NOPS];         // 0 random grant, 1 every 8th cycle, 2 always
    int            op = 0;

    function automatic logic [DW-1:0] memrd(logic [AW-1:0] a);
        if (mem_m.exists(int'(a))) return mem_m[int'(a)];
        return (DW'(a) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    endfunction

    task automatic check(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // One clock: drive at the falling edge, compare, then advance the model.
    task automatic cycle(input bit use_cpu);
        bit            ereq, ewe, eack, hit, gpol;
        logic [AW-1:0] eaddr;
        logic [DW-1:0] ewd, erd;
        logic [IW-1:0] idx;
        logic [AW-IW-1:0] tg;
        int            sz, gm;
        string         tack, tmem;
        @(negedge clk);
        cyc++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (use_cpu && op < NOPS) begin
            cpu_req = 1'b1; cpu_we = op_we[op]; cpu_addr = op_a[op]; cpu_wdata = op_d[op];
            gm = op_gm[op];
        end else begin
            cpu_req = 1'b0; gm = 2;
        end
        sz    = wq.size();
        ereq  = (sz > 0) || (mode == 2);
        ewe   = (sz > 0);
        eaddr = (sz > 0) ? wq[0].a : cpu_addr;
        ewd   = (sz > 0) ? wq[0].d : '0;
        gpol  = (gm == 2) ? 1'b1 : (gm == 1) ? ((cyc % 8) == 0) : lfsr[0];
        mem_gnt    = ereq && gpol;
        mem_rvalid = rp && (rw == 0);
        mem_rdata  = mem_rvalid ? rd_d : '0;
        #1;
        idx = cpu_addr[IW-1:0];
        tg  = cpu_addr[AW-1:IW];
        hit = mv[idx] && (mt[idx] == tg);
        eack = 1'b0; erd = '0;
        if (mode == 0) begin
            eack = cpu_req && (cpu_we ? (sz < DEPTH) : hit);
            erd  = md[idx];
            if (post_rst) tack = "R9";
            else if (cpu_we) tack = (sz < DEPTH) ? "R5" : "R7";
            else if (hit) tack = (sz > 0) ? "R10" : "R2";
            else tack = mv[idx] ? "R1" : "R3";
        end else if (mode == 3) begin
            eack = mem_rvalid; erd = rd_d; tack = "R4";
        end else begin
            tack = (mode == 1) ? "R8" : "R3";
        end
        check(cpu_ack === eack, tack, "cpu_ack", DW'(cpu_ack), DW'(eack));
        if (eack && !cpu_we)
            check(cpu_rdata === erd, (mode == 3) ? "R4" : "R2", "cpu_rdata", cpu_rdata, erd);
        tmem = prev_wait ? "R11" : (ewe ? "R6" : (mode == 2 ? "R3" : "R8"));
        check(mem_req === ereq, tmem, "mem_req", DW'(mem_req), DW'(ereq));
        if (ereq) begin
            check(mem_we === ewe, tmem, "mem_we", DW'(mem_we), DW'(ewe));
            check(mem_addr === eaddr, tmem, "mem_addr", DW'(mem_addr), DW'(eaddr));
            if (ewe) check(mem_wdata === ewd, tmem, "mem_wdata", mem_wdata, ewd);
        end
        prev_wait = ereq && !mem_gnt;
        // Model update for the coming rising edge
        if (mem_gnt && sz > 0) begin
            mem_m[int'(wq[0].a)] = wq[0].d;
            void'(wq.pop_front());
        end
        if (rp) begin
            if (mem_rvalid) rp = 0; else rw--;
        end
        case (mode)
            0: begin
                if (eack && cpu_we) begin
                    mv[idx] = 1; mt[idx] = tg; md[idx] = cpu_wdata;
                    wq.push_back('{a: cpu_addr, d: cpu_wdata});
                end else if (cpu_req && !cpu_we && !hit) begin
                    mode = (sz == 0) ? 2 : 1;
                end
            end
            1: if (sz == 0) mode = 2;
            2: if (mem_gnt) begin
                   mode = 3; rp = 1; rw = int'(lfsr[2:1] % 3); rd_d = memrd(cpu_addr);
               end
            3: if (mem_rvalid) begin
                   mv[idx] = 1; mt[idx] = tg; md[idx] = rd_d; mode = 0;
               end
            default: mode = 0;
        endcase
        if (eack) begin
            op++;
            if (!cpu_we) post_rst = 0;
        end
    endtask

    task automatic add_op(inout int n, input bit we, input logic [AW-1:0] a, input int gm);
        op_we[n] = we; op_a[n] = a; op_d[n] = $urandom(); op_gm[n] = gm; n++;
    endtask

    initial begin
        int n = 0, stuck = 0, last_op = 0;
        // Cold misses, then hits (R3, R4, R2)
        for (int i = 0; i < 8; i++) add_op(n, 0, AW'(i), 0);
        for (int i = 0; i < 8; i++) add_op(n, 0, AW'(i), 2);
        // Write burst with slow grants: queue fills and stalls (R5, R6, R7)
        for (int i = 0; i < 7; i++) add_op(n, 1, AW'(16 + i), 1);
        // Hits while draining (R10)
        for (int i = 0; i < 4; i++) add_op(n, 0, AW'(i), 1);
        // Alias on index 5: write, conflicting read, re-read (R1, R8)
        add_op(n, 1, AW'(12'h035), 1);
        add_op(n, 0, AW'(12'h005), 1);
        add_op(n, 0, AW'(12'h035), 0);
        // Random mix over four tags
        while (n < RST_AT) add_op(n, ($urandom_range(0, 9) < 4),
                                  AW'({$urandom_range(0, 3), 4'($urandom_range(0, 15))}),
                                  $urandom_range(0, 2));
        // After reset: previously touched addresses must miss (R9)
        while (n < NOPS) add_op(n, ($urandom_range(0, 9) < 3),
                                AW'({$urandom_range(0, 3), 4'($urandom_range(0, 15))}), 0);

        for (int i = 0; i < 3; i++) cycle(0);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check(cpu_ack === 1'b0, "R9", "cpu_ack after reset", DW'(cpu_ack), 0);
        check(mem_req === 1'b0, "R9", "mem_req after reset", DW'(mem_req), 0);

        while (op < NOPS && stuck < 3000) begin
            if (op == RST_AT && !post_rst) begin
                for (int k = 0; k < 200 && (wq.size() > 0 || mode != 0 || rp); k++) cycle(0);
                @(negedge clk); rst_n = 1'b0; cpu_req = 1'b0; mem_gnt = 1'b0; mem_rvalid = 1'b0;
                @(negedge clk);
                #1;
                check(mem_req === 1'b0 && cpu_ack === 1'b0, "R9", "outputs in reset",
                      DW'({mem_req, cpu_ack}), 0);
                rst_n = 1'b1;
                for (int l = 0; l < LINES; l++) mv[l] = 0;
                wq.delete(); mode = 0; rp = 0; prev_wait = 0; post_rst = 1;
            end
            cycle(1);
            if (op != last_op) begin last_op = op; stuck = 0; end else stuck++;
        end
        if (stuck >= 3000) begin
            checks++; errors++;
            $display("FAIL watchdog: no progress at op %0d actual=stuck expected=progress", op);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 190000);
        checks++; errors++;
        $display("FAIL watchdog: run time exceeded actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule